// File: doc/BRIEF.md
# Wormhole Header Router

This block sits behind one receive link channel and steers its incoming packets to one of several outputs: the other link channels or the local endpoint. The input is a token stream: each token is either a data byte or an end-of-packet marker of one of two kinds. When routing is on, the first data token of each packet is a destination byte. It is compared against four programmable 8-bit addresses, one per link and one for the local endpoint, and then removed. Every later token of that packet, up to and including its end marker, goes to the chosen output.

The block never drops a packet whose destination byte matches nothing. That packet goes to the local endpoint, and a sticky error flag is raised. The flag drives an interrupt line through a mask input. With routing off, the block passes every token unchanged to the local endpoint. The link the stream arrives on is fixed by a parameter, and a destination that names that same link counts as a miss.

Outputs are registered, one valid/data/end stream per port. Port numbers 0 to NUM_LINKS-1 are the links, and port NUM_LINKS is the local endpoint. There is no flow control, and the block does not arbitrate between several inputs.

Top module: `wormhole_hdr_router`

## Requirements
- R1: During and right after reset no output port is valid, the interrupt is low, and the next data token is treated as a header.
- R2: With routing on, the first data token of a packet is consumed as the destination and appears on no output.
- R3: A destination equal to the address of link i, where i is not the arrival link SRC_LINK, sends the rest of the packet to port i with data unchanged.
- R4: A destination equal to the local address sends the rest of the packet to port NUM_LINKS (the local port).
- R5: A destination that matches no eligible address, including the arrival link's own address, sends the packet to the local port and sets the error flag.
- R6: The interrupt equals error flag AND err_mask. The flag stays set until err_clr is high on a clock edge, and a new miss on the same edge as err_clr wins over the clear.
- R7: The route chosen by a header holds for every token of the packet. After the end marker passes, the next data token is a new header.
- R8: A header followed directly by an end marker produces a lone end marker on the chosen port.
- R9: With route_en low, every token, including a would-be header byte, goes unchanged to the local port and the error flag is not set.
- R10: The end-marker kind bit (0 or 1) is carried unchanged to the output. An end marker that arrives while a header is expected goes to the local port.
- R11: When several addresses equal the destination, the local address wins, then the lowest-numbered eligible link.
- R12: Each forwarded token appears exactly one clock after it is accepted, and at most one port is valid per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| route_en | input | 1 | Routing on (1) or all-to-local (0) |
| link_addr | input | 8*NUM_LINKS | Address of link i in bits [8i+7:8i] |
| local_addr | input | 8 | Address of the local endpoint |
| err_mask | input | 1 | Interrupt enable for the error flag |
| err_clr | input | 1 | Clears the error flag |
| in_valid | input | 1 | Input token present |
| in_data | input | 8 | Data byte of the token |
| in_eop | input | 1 | Token is an end marker |
| in_eop_kind | input | 1 | Kind of end marker (0 or 1) |
| out_valid | output | NUM_LINKS+1 | Per-port token valid |
| out_data | output | 8*(NUM_LINKS+1) | Per-port byte, port p in bits [8p+7:8p] |
| out_eop | output | NUM_LINKS+1 | Per-port end marker |
| out_eop_kind | output | NUM_LINKS+1 | Per-port end-marker kind |
| route_irq | output | 1 | Masked routing error interrupt |

## Verification
The bench builds the router with three links and SRC_LINK set to 1, not the default 0. This puts link 0 below the arrival link and link 2 above it, so the bench checks both sides of the exclusion. It also makes a header naming link 1 a miss that must fall back to the local port. In the priority cases the bench gives the local endpoint and a link the same address, and then two links the same address. Between these it changes the addresses at run time, so one build covers the tie rules.

// File: rtl/rw_route_pkg.sv
package rw_route_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              eop;
        logic              kind;
        logic [BYTE_W-1:0] data;
    } tok_t;

    typedef enum logic {
        ST_HDR  = 1'b0,
        ST_BODY = 1'b1
    } steer_st_e;

    function automatic int port_w(input int links);
        return (links + 1 > 1) ? $clog2(links + 1) : 1;
    endfunction

endpackage

// File: rtl/rw_hdr_match.sv
module rw_hdr_match
    import rw_route_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int SRC_LINK  = 0,
    localparam int PW = port_w(NUM_LINKS)
) (
    input  logic [BYTE_W-1:0]           hdr,
    input  logic [NUM_LINKS*BYTE_W-1:0] link_addr,
    input  logic [BYTE_W-1:0]           local_addr,
    output logic [PW-1:0]               dest,
    output logic                        miss
);

    logic [NUM_LINKS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_LINKS; g++) begin : g_cmp
            if (g == SRC_LINK) begin : g_self
                assign hit[g] = 1'b0;
            end else begin : g_other
                assign hit[g] = (link_addr[g*BYTE_W +: BYTE_W] == hdr);
            end
        end
    endgenerate

    always_comb begin
        dest = PW'(NUM_LINKS);
        miss = 1'b1;
        if (hdr == local_addr) begin
            miss = 1'b0;
        end else begin
            for (int i = NUM_LINKS - 1; i >= 0; i--) begin
                if (hit[i]) begin
                    dest = PW'(i);
                    miss = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/rw_steer_fsm.sv
module rw_steer_fsm
    import rw_route_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    localparam int PW = port_w(NUM_LINKS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          route_en,
    input  logic          in_valid,
    input  tok_t          in_tok,
    input  logic [PW-1:0] match_dest,
    input  logic          match_miss,
    output logic          fwd_valid,
    output logic [PW-1:0] fwd_port,
    output logic          miss_evt
);

    localparam logic [PW-1:0] LOCAL_PORT = PW'(NUM_LINKS);

    steer_st_e     st_q, st_n;
    logic [PW-1:0] dest_q, dest_n;

    always_comb begin
        st_n      = route_en ? st_q : ST_HDR;
        dest_n    = dest_q;
        fwd_valid = 1'b0;
        fwd_port  = LOCAL_PORT;
        miss_evt  = 1'b0;
        if (in_valid) begin
            if (!route_en) begin
                fwd_valid = 1'b1;
            end else if (st_q == ST_HDR) begin
                if (in_tok.eop) begin
                    fwd_valid = 1'b1;
                end else begin
                    dest_n   = match_dest;
                    miss_evt = match_miss;
                    st_n     = ST_BODY;
                end
            end else begin
                fwd_valid = 1'b1;
                fwd_port  = dest_q;
                if (in_tok.eop) st_n = ST_HDR;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HDR;
            dest_q <= LOCAL_PORT;
        end else begin
            st_q   <= st_n;
            dest_q <= dest_n;
        end
    end

endmodule

// File: rtl/rw_out_stage.sv
module rw_out_stage
    import rw_route_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    localparam int NPORT = NUM_LINKS + 1,
    localparam int PW = port_w(NUM_LINKS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fwd_valid,
    input  logic [PW-1:0]           fwd_port,
    input  tok_t                    tok,
    output logic [NPORT-1:0]        out_valid,
    output logic [NPORT*BYTE_W-1:0] out_data,
    output logic [NPORT-1:0]        out_eop,
    output logic [NPORT-1:0]        out_eop_kind
);

    genvar p;
    generate
        for (p = 0; p < NPORT; p++) begin : g_port
            logic sel;
            assign sel = fwd_valid && (fwd_port == PW'(p));
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid[p]                  <= 1'b0;
                    out_data[p*BYTE_W +: BYTE_W]  <= '0;
                    out_eop[p]                    <= 1'b0;
                    out_eop_kind[p]               <= 1'b0;
                end else begin
                    out_valid[p] <= sel;
                    if (sel) begin
                        out_data[p*BYTE_W +: BYTE_W] <= tok.data;
                        out_eop[p]                   <= tok.eop;
                        out_eop_kind[p]              <= tok.kind;
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/rw_err_irq.sv
module rw_err_irq (
    input  logic clk,
    input  logic rst,
    input  logic miss_evt,
    input  logic err_clr,
    input  logic err_mask,
    output logic route_irq
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (miss_evt) flag_q <= 1'b1;
        else if (err_clr)  flag_q <= 1'b0;
    end

    assign route_irq = flag_q & err_mask;

endmodule

// File: rtl/wormhole_hdr_router.sv
module wormhole_hdr_router
    import rw_route_pkg::*;
#(
    parameter int NUM_LINKS = 3,
    parameter int SRC_LINK  = 0,
    localparam int NPORT = NUM_LINKS + 1,
    localparam int PW = port_w(NUM_LINKS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        route_en,
    input  logic [NUM_LINKS*BYTE_W-1:0] link_addr,
    input  logic [BYTE_W-1:0]           local_addr,
    input  logic                        err_mask,
    input  logic                        err_clr,
    input  logic                        in_valid,
    input  logic [BYTE_W-1:0]           in_data,
    input  logic                        in_eop,
    input  logic                        in_eop_kind,
    output logic [NPORT-1:0]            out_valid,
    output logic [NPORT*BYTE_W-1:0]     out_data,
    output logic [NPORT-1:0]            out_eop,
    output logic [NPORT-1:0]            out_eop_kind,
    output logic                        route_irq
);

    tok_t          tok;
    logic [PW-1:0] m_dest;
    logic          m_miss;
    logic          fwd_valid;
    logic [PW-1:0] fwd_port;
    logic          miss_evt;

    assign tok = '{eop: in_eop, kind: in_eop_kind, data: in_data};

    rw_hdr_match #(.NUM_LINKS(NUM_LINKS), .SRC_LINK(SRC_LINK)) u_match (
        .hdr        (in_data),
        .link_addr  (link_addr),
        .local_addr (local_addr),
        .dest       (m_dest),
        .miss       (m_miss)
    );

    rw_steer_fsm #(.NUM_LINKS(NUM_LINKS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .route_en   (route_en),
        .in_valid   (in_valid),
        .in_tok     (tok),
        .match_dest (m_dest),
        .match_miss (m_miss),
        .fwd_valid  (fwd_valid),
        .fwd_port   (fwd_port),
        .miss_evt   (miss_evt)
    );

    rw_out_stage #(.NUM_LINKS(NUM_LINKS)) u_out (
        .clk          (clk),
        .rst          (rst),
        .fwd_valid    (fwd_valid),
        .fwd_port     (fwd_port),
        .tok          (tok),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .out_eop      (out_eop),
        .out_eop_kind (out_eop_kind)
    );

    rw_err_irq u_err (
        .clk       (clk),
        .rst       (rst),
        .miss_evt  (miss_evt),
        .err_clr   (err_clr),
        .err_mask  (err_mask),
        .route_irq (route_irq)
    );

endmodule

// File: rtl/rw_route_chk.sv
module rw_route_chk #(
    parameter int NUM_LINKS = 3,
    localparam int NPORT = NUM_LINKS + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             route_en,
    input logic             err_mask,
    input logic             err_clr,
    input logic             in_valid,
    input logic [NPORT-1:0] out_valid,
    input logic             route_irq
);

    assert_onehot_port_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_valid));

    assert_out_follows_in_R12: assert property (@(posedge clk) disable iff (rst)
        (|out_valid) |-> $past(in_valid));

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (rst)
        route_irq |-> err_mask);

    assert_clear_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !in_valid) |=> !route_irq);

    assert_bypass_local_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !route_en) |=> out_valid[NUM_LINKS]);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (out_valid == '0 && !route_irq));

endmodule

bind wormhole_hdr_router rw_route_chk #(.NUM_LINKS(NUM_LINKS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .route_en  (route_en),
    .err_mask  (err_mask),
    .err_clr   (err_clr),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .route_irq (route_irq)
);

// File: tb/tb_wormhole_hdr_router.sv
module tb_wormhole_hdr_router;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 3;
    localparam int NP = NL + 1;
    localparam int LOC = NL;

    typedef struct {
        int       port;
        bit [7:0] data;
        bit       eop;
        bit       kind;
        string    req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              route_en = 1'b0;
    logic [NL*8-1:0]   link_addr = '0;
    logic [7:0]        local_addr = '0;
    logic              err_mask = 1'b0;
    logic              err_clr = 1'b0;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = '0;
    logic              in_eop = 1'b0;
    logic              in_eop_kind = 1'b0;
    logic [NP-1:0]     out_valid;
    logic [NP*8-1:0]   out_data;
    logic [NP-1:0]     out_eop;
    logic [NP-1:0]     out_eop_kind;
    logic              route_irq;

    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wormhole_hdr_router #(.NUM_LINKS(NL), .SRC_LINK(1)) dut (
        .clk(clk), .rst(rst), .route_en(route_en), .link_addr(link_addr),
        .local_addr(local_addr), .err_mask(err_mask), .err_clr(err_clr),
        .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
        .in_eop_kind(in_eop_kind), .out_valid(out_valid), .out_data(out_data),
        .out_eop(out_eop), .out_eop_kind(out_eop_kind), .route_irq(route_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit eop, input bit kind, input bit [7:0] d,
                         input int port, input string req);
        in_valid    = 1'b1;
        in_eop      = eop;
        in_eop_kind = kind;
        in_data     = d;
        if (port >= 0) q.push_back('{port, d, eop, kind, req});
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        in_data  = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                check($countones(out_valid) <= 1, "R12 one port", int'(out_valid), 0);
                for (int p = 0; p < NP; p++) begin
                    if (out_valid[p]) begin
                        if (q.size() == 0) begin
                            check(0, "R12 unexpected token", p, -1);
                        end else begin
                            exp_t e;
                            e = q.pop_front();
                            check(p == e.port, {e.req, " port"}, p, e.port);
                            check(out_data[p*8 +: 8] == e.data, {e.req, " data"},
                                  int'(out_data[p*8 +: 8]), int'(e.data));
                            check(out_eop[p] == e.eop && out_eop_kind[p] == e.kind,
                                  {e.req, " eop/kind"},
                                  int'({out_eop[p], out_eop_kind[p]}), int'({e.eop, e.kind}));
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        link_addr  = {8'h32, 8'h21, 8'h10};
        local_addr = 8'h40;
        @(negedge clk); @(negedge clk);
        check(out_valid == '0, "R1 reset valid", int'(out_valid), 0);
        check(route_irq == 1'b0, "R1 reset irq", int'(route_irq), 0);
        rst = 1'b0;
        route_en = 1'b1;
        err_mask = 1'b1;
        idle(1);
        check(out_valid == '0, "R1 idle after reset", int'(out_valid), 0);

        // R2 R3 R7 R10: to link 0, kind 0
        drive(0, 0, 8'h10, -1, "R2");
        drive(0, 0, 8'hA1, 0, "R3 link0");
        drive(0, 0, 8'hA2, 0, "R7 hold");
        drive(1, 0, 8'h00, 0, "R10 kind0");
        // back-to-back packet to link 2, kind 1
        drive(0, 0, 8'h32, -1, "R7 new header");
        drive(0, 0, 8'hB1, 2, "R3 link2");
        drive(1, 1, 8'h00, 2, "R10 kind1");
        // R4 local
        drive(0, 0, 8'h40, -1, "R4");
        drive(0, 0, 8'hC1, LOC, "R4 local");
        drive(0, 0, 8'hC2, LOC, "R4 local");
        drive(1, 0, 8'h00, LOC, "R4 eop");
        idle(2);
        check(route_irq == 1'b0, "R5 no error on matches", int'(route_irq), 0);

        // R5: own link address is a miss
        drive(0, 0, 8'h21, -1, "R5");
        drive(0, 0, 8'hD1, LOC, "R5 own-link to local");
        drive(1, 0, 8'h00, LOC, "R5 eop");
        idle(1);
        check(route_irq == 1'b1, "R5 irq on own link", int'(route_irq), 1);
        err_clr = 1'b1; idle(1); err_clr = 1'b0;
        check(route_irq == 1'b0, "R6 clear", int'(route_irq), 0);

        // R6 mask
        err_mask = 1'b0;
        drive(0, 0, 8'h99, -1, "R5");
        drive(0, 0, 8'hE1, LOC, "R5 unknown to local");
        drive(1, 1, 8'h00, LOC, "R5 eop");
        idle(1);
        check(route_irq == 1'b0, "R6 masked", int'(route_irq), 0);
        err_mask = 1'b1;
        #1;
        check(route_irq == 1'b1, "R6 sticky unmask", int'(route_irq), 1);
        err_clr = 1'b1; idle(1); err_clr = 1'b0;
        check(route_irq == 1'b0, "R6 clear again", int'(route_irq), 0);

        // R6 set wins over clear
        err_clr = 1'b1;
        drive(0, 0, 8'h77, -1, "R6");
        err_clr = 1'b0;
        check(route_irq == 1'b1, "R6 set over clear", int'(route_irq), 1);
        drive(1, 0, 8'h00, LOC, "R6 eop");
        err_clr = 1'b1; idle(1); err_clr = 1'b0;

        // R8 header then eop
        drive(0, 0, 8'h10, -1, "R8");
        drive(1, 1, 8'h00, 0, "R8 lone eop");
        // R10 stray eop at header position
        drive(1, 0, 8'h00, LOC, "R10 stray eop");
        drive(0, 0, 8'h32, -1, "R10 header after stray");
        drive(0, 0, 8'h5A, 2, "R10 still routes");
        drive(1, 0, 8'h00, 2, "R10 eop");

        // R9 routing disabled
        route_en = 1'b0;
        drive(0, 0, 8'h10, LOC, "R9 header byte kept");
        drive(0, 0, 8'h55, LOC, "R9 data");
        drive(1, 1, 8'h00, LOC, "R9 eop");
        drive(0, 0, 8'h99, LOC, "R9 no miss");
        idle(1);
        check(route_irq == 1'b0, "R9 no error", int'(route_irq), 0);
        route_en = 1'b1;

        // R11 priority
        link_addr = {8'h40, 8'h21, 8'h10};
        drive(0, 0, 8'h40, -1, "R11");
        drive(0, 0, 8'h61, LOC, "R11 local over link");
        drive(1, 0, 8'h00, LOC, "R11 eop");
        link_addr = {8'h10, 8'h21, 8'h10};
        drive(0, 0, 8'h10, -1, "R11");
        drive(0, 0, 8'h62, 0, "R11 lowest link");
        drive(1, 0, 8'h00, 0, "R11 eop");
        idle(3);
        check(route_irq == 1'b0, "R11 no error", int'(route_irq), 0);
        check(q.size() == 0, "R12 all tokens delivered", q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule